// File: doc/BRIEF.md
# Object Overlap Collision Flags

This block watches six graphics objects as the renderer draws them: two players, two missiles, a ball and a playfield. On each clock it checks every pair of objects for a shared lit pixel. A pair that overlaps inside the visible region sets a sticky flag, and the flag stays set until software clears it. Overlaps that occur during blanking are ignored.

Software reads the flags through eight read registers on a shared register bus. Each register holds two flags in data bits 7 and 6. A single write strobe to one fixed address clears every flag at once, whatever data comes with it. The bus accesses are sorted into four named operations: OP_IDLE (enable low), OP_READ (enable high, write line low), OP_CLEAR (a write to the clear address) and OP_WRITE (any other write, which has no effect here). Read data is registered.

Top module: `objcollide_latches`

## Requirements
- R1: While the active-low `rst_n` is low, every flag and `rd_data` are cleared at once, without waiting for a clock edge.
- R2: A flag sets at the clock edge that ends a cycle in which `vis_en` is high and both objects of its pair have their `obj_on` bits high. The object bits are bit0 P0, bit1 P1, bit2 M0, bit3 M1, bit4 BL and bit5 PF.
- R3: A flag that is set stays set for any later pixel input, until a clear or a reset.
- R4: While `vis_en` is low, no flag sets, whatever `obj_on` holds.
- R5: The read address picks the flags as follows, listed as {bit7, bit6}. 0: {M0-P1, M0-P0}. 1: {M1-P0, M1-P1}. 2: {P0-PF, P0-BL}. 3: {P1-PF, P1-BL}. 4: {M0-PF, M0-BL}. 5: {M1-PF, M1-BL}. 6: {BL-PF, 0}. 7: {P0-P1, M0-M1}.
- R6: Bits 5:0 of the read data are always zero. Bit 6 of register 6 always reads zero.
- R7: `rd_data` updates one clock after an OP_READ to addresses 0 to 7 and shows the flags as they stood before that edge. Every other cycle, including a read of any other address, leaves `rd_data` unchanged.
- R8: An OP_CLEAR (write to address 0x2C) clears all fifteen flags at its clock edge.
- R9: When a set condition and an OP_CLEAR fall in the same cycle, the clear wins and the flag is zero afterwards.
- R10: With `bus_en` low the bus does nothing. A write to any address other than 0x2C changes no flag.
- R11: A lit object with no other lit object sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vis_en | input | 1 | High while the beam is in the visible region |
| obj_on | input | 6 | Pixel-on bit for each object (P0, P1, M0, M1, BL, PF from bit 0) |
| bus_en | input | 1 | Register bus select |
| bus_wr | input | 1 | 1 means write, 0 means read |
| bus_addr | input | ADDR_W (6) | Register address |
| rd_data | output | 8 | Registered read data, flags in bits 7 and 6 |

## Verification
Each of the fifteen pairs is lit alone and every register is read back. A design that routed a flag to the wrong register or bit, or that swapped bits 7 and 6, fails at once. Single lit objects and a fully lit frame during blanking must leave every register at zero, which catches detectors that ignore the partner object or the visible gate. A clear that lands on the same cycle as a full overlap must leave zero; a design where the set wins reads back 0xC0. Writes to other addresses, a clear with enable low, and reads of out-of-range addresses must leave the flags and `rd_data` unchanged, which catches decoders that miss the enable or the full address compare.

// File: rtl/objcollide_pkg.sv
package objcollide_pkg;

    localparam int NUM_OBJ     = 6;
    localparam int NUM_SLOTS   = 16;
    localparam int NUM_RD_REGS = NUM_SLOTS / 2;
    localparam int DATA_W      = 8;

    localparam int OBJ_P0 = 0;
    localparam int OBJ_P1 = 1;
    localparam int OBJ_M0 = 2;
    localparam int OBJ_M1 = 3;
    localparam int OBJ_BL = 4;
    localparam int OBJ_PF = 5;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_CLEAR,
        OP_WRITE
    } bus_op_e;

    // Slot 2r lands in bit 7 of read register r, slot 2r+1 in bit 6.
    function automatic int slot_obj_a(int s);
        case (s)
            0, 1, 9, 8, 15: return OBJ_M0;
            2, 3, 10, 11:   return OBJ_M1;
            4, 5, 14:       return OBJ_P0;
            6, 7:           return OBJ_P1;
            12:             return OBJ_BL;
            default:        return OBJ_P0;
        endcase
    endfunction

    function automatic int slot_obj_b(int s);
        case (s)
            0, 3, 14:       return OBJ_P1;
            1, 2:           return OBJ_P0;
            4, 6, 8, 10, 12: return OBJ_PF;
            5, 7, 9, 11:    return OBJ_BL;
            15:             return OBJ_M1;
            default:        return OBJ_P0;
        endcase
    endfunction

    function automatic bit slot_used(int s);
        return (s != 13);
    endfunction

endpackage

// File: rtl/coll_pair_detect.sv
module coll_pair_detect
    import objcollide_pkg::*;
(
    input  logic                 vis_en,
    input  logic [NUM_OBJ-1:0]   obj_on,
    output logic [NUM_SLOTS-1:0] hit
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (slot_used(s)) begin : g_pair
            localparam int OA = slot_obj_a(s);
            localparam int OB = slot_obj_b(s);
            assign hit[s] = vis_en & obj_on[OA] & obj_on[OB];
        end else begin : g_empty
            assign hit[s] = 1'b0;
        end
    end

endmodule

// File: rtl/coll_latch_bank.sv
module coll_latch_bank
    import objcollide_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_SLOTS-1:0] hit,
    output logic [NUM_SLOTS-1:0] lat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= '0;
        end else if (clr) begin
            lat <= '0;
        end else begin
            lat <= lat | hit;
        end
    end

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lat == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((lat & $past(lat)) == $past(lat)));

    // R2
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((lat & $past(hit)) == $past(hit)));

endmodule

// File: rtl/coll_read_mux.sv
module coll_read_mux
    import objcollide_pkg::*;
#(
    parameter int RD_IDX_W = $clog2(NUM_RD_REGS)
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [RD_IDX_W-1:0]  rd_idx,
    input  logic [NUM_SLOTS-1:0] lat,
    output logic [DATA_W-1:0]    rd_data
);

    logic [1:0] grp [NUM_RD_REGS];

    for (genvar r = 0; r < NUM_RD_REGS; r++) begin : g_grp
        assign grp[r] = {lat[2*r], lat[2*r+1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= {grp[rd_idx], {(DATA_W-2){1'b0}}};
        end
    end

    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-3:0] == '0);

    // R6
    reg6_bit6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_idx == RD_IDX_W'(6)) |=> !rd_data[DATA_W-2]);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

endmodule

// File: rtl/objcollide_latches.sv
module objcollide_latches
    import objcollide_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 6'h2C
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vis_en,
    input  logic [NUM_OBJ-1:0]   obj_on,
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    rd_data
);

    localparam int RD_IDX_W = $clog2(NUM_RD_REGS);
    localparam logic [ADDR_W-1:0] RD_LIMIT = ADDR_W'(NUM_RD_REGS);

    bus_op_e                op;
    logic                   clr;
    logic                   rd_req;
    logic [NUM_SLOTS-1:0]   hit;
    logic [NUM_SLOTS-1:0]   lat;

    always_comb begin
        op = OP_IDLE;
        if (bus_en) begin
            if (!bus_wr)                  op = OP_READ;
            else if (bus_addr == CLR_ADDR) op = OP_CLEAR;
            else                          op = OP_WRITE;
        end
    end

    always_comb begin
        clr    = 1'b0;
        rd_req = 1'b0;
        unique case (op)
            OP_IDLE:  ;
            OP_READ:  rd_req = (bus_addr < RD_LIMIT);
            OP_CLEAR: clr = 1'b1;
            OP_WRITE: ;
        endcase
    end

    coll_pair_detect u_detect (
        .vis_en (vis_en),
        .obj_on (obj_on),
        .hit    (hit)
    );

    coll_latch_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (hit),
        .lat   (lat)
    );

    coll_read_mux #(.RD_IDX_W(RD_IDX_W)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_idx  (bus_addr[RD_IDX_W-1:0]),
        .lat     (lat),
        .rd_data (rd_data)
    );

    // R4
    blank_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_en |=> ((lat & ~$past(lat)) == '0));

    // R10
    bus_idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en && !vis_en) |=> $stable(lat));

    // R8
    clear_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == CLR_ADDR) |=> (lat == '0));

endmodule

// File: tb/objcollide_latches_tb.sv
module objcollide_latches_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vis_en = 1'b0;
    logic [5:0] obj_on = '0;
    logic       bus_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    exp_t q[$];
    logic [15:0] m_lat = '0;
    logic [7:0]  m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    objcollide_latches u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vis_en   (vis_en),
        .obj_on   (obj_on),
        .bus_en   (bus_en),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rd_data  (rd_data)
    );

    // Pair table from R5: slot 2r -> bit7 of reg r, slot 2r+1 -> bit6.
    // Objects: 0 P0, 1 P1, 2 M0, 3 M1, 4 BL, 5 PF.
    function automatic logic [5:0] pair_mask(int s);
        case (s)
            0:  return 6'b000110; // M0-P1
            1:  return 6'b000101; // M0-P0
            2:  return 6'b001001; // M1-P0
            3:  return 6'b001010; // M1-P1
            4:  return 6'b100001; // P0-PF
            5:  return 6'b010001; // P0-BL
            6:  return 6'b100010; // P1-PF
            7:  return 6'b010010; // P1-BL
            8:  return 6'b100100; // M0-PF
            9:  return 6'b010100; // M0-BL
            10: return 6'b101000; // M1-PF
            11: return 6'b011000; // M1-BL
            12: return 6'b110000; // BL-PF
            14: return 6'b000011; // P0-P1
            15: return 6'b001100; // M0-M1
            default: return 6'b000000;
        endcase
    endfunction

    function automatic logic [15:0] model_hits(logic [5:0] on, logic vis);
        logic [15:0] h = '0;
        for (int s = 0; s < 16; s++) begin
            if (pair_mask(s) != 0 && vis && ((on & pair_mask(s)) == pair_mask(s)))
                h[s] = 1'b1;
        end
        return h;
    endfunction

    task automatic step(input logic [5:0] on, input logic vis, input logic en,
                        input logic wr, input logic [5:0] addr, input string tag);
        @(negedge clk);
        obj_on = on; vis_en = vis; bus_en = en; bus_wr = wr; bus_addr = addr;
        if (en && !wr && addr < 6'd8)
            m_rd = {m_lat[2*addr], m_lat[2*addr+1], 6'b0};
        if (en && wr && addr == 6'h2C) m_lat = '0;
        else m_lat = m_lat | model_hits(on, vis);
        q.push_back('{m_rd, tag});
        @(posedge clk);
    endtask

    task automatic rd(input logic [5:0] addr, input string tag);
        step(6'b0, 1'b0, 1'b1, 1'b0, addr, tag);
    endtask

    task automatic clear(input string tag);
        step(6'b0, 1'b0, 1'b1, 1'b1, 6'h2C, tag);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) rd(6'(a), tag);
    endtask

    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            #1;
            it = q.pop_front();
            checks++;
            if (rd_data !== it.val) begin
                failures++;
                $display("FAIL %s: rd_data actual=%h expected=%h", it.tag, rd_data, it.val);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 2);
        checks++;
        if (rd_data !== 8'h00) begin
            failures++;
            $display("FAIL R1: reset rd_data actual=%h expected=00", rd_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R1 post-reset zero");

        // R2 / R5: each pair alone
        for (int s = 0; s < 16; s++) begin
            if (pair_mask(s) != 0) begin
                clear("R8 clear before pair");
                step(pair_mask(s), 1'b1, 1'b0, 1'b0, 6'h00, "R2 pair drive");
                read_all("R5 pair map");
            end
        end

        // R11: lone objects
        clear("R8 clear");
        for (int o = 0; o < 6; o++) step(6'(1 << o), 1'b1, 1'b0, 1'b0, 6'h00, "R11 lone");
        read_all("R11 lone object sets nothing");

        // R4: blanking
        step(6'h3F, 1'b0, 1'b0, 1'b0, 6'h00, "R4 blank");
        read_all("R4 blanking ignored");

        // R6 / R3: all on, then sticky
        step(6'h3F, 1'b1, 1'b0, 1'b0, 6'h00, "R2 all on");
        read_all("R6 full pattern");
        for (int k = 0; k < 5; k++) step(6'h00, 1'b1, 1'b0, 1'b0, 6'h00, "R3 idle");
        read_all("R3 sticky");

        // R10: other writes and disabled clear
        step(6'h00, 1'b1, 1'b1, 1'b1, 6'h2B, "R10 other write");
        step(6'h00, 1'b1, 1'b1, 1'b1, 6'h00, "R10 write addr0");
        step(6'h00, 1'b1, 1'b0, 1'b1, 6'h2C, "R10 disabled clear");
        read_all("R10 no effect");

        // R7: hold on non-reads and out-of-range reads
        rd(6'h07, "R7 read reg7");
        rd(6'h09, "R7 out of range hold");
        rd(6'h2C, "R7 read clear addr hold");
        step(6'h00, 1'b0, 1'b0, 1'b0, 6'h03, "R7 disabled read hold");

        // R8 clear
        clear("R8 clear all");
        read_all("R8 cleared");

        // R9: clear and set same cycle
        step(6'h3F, 1'b1, 1'b1, 1'b1, 6'h2C, "R9 clear with set");
        read_all("R9 clear wins");

        // R2: set during a read sees old value, then new
        step(6'b000011, 1'b1, 1'b1, 1'b0, 6'h07, "R7 read sees pre-edge");
        rd(6'h07, "R2 P0-P1 set");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule